// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit resolves the operand of a load in a general-register machine. A caller presents a mode code, an address constant and two register selectors, then pulses `start`. The unit reads any registers it needs through one register-file read port. It then issues one or two word reads on a memory port that uses a request/valid handshake. When it has the final operand it returns it together with a one-cycle `done` pulse.

Seven addressing forms are supported: absolute, indexed, memory-indirect, register-indirect and base-plus-index. Indirection can be combined with indexing in either order: the index can be added to the pointer after it is fetched, or to the constant before the pointer is fetched. The indirect forms need two memory reads; every other form needs one. All address arithmetic is done in the word width and wraps. One mode code is reserved. It reports an error and does not touch memory.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (absolute) returns M[k], where k is `addr_const`, using exactly one memory read.
- R2: Mode code 1 (indexed) returns M[(k + X) mod 2^W], where X is the register chosen by `idx_sel`, using one memory read.
- R3: Mode code 2 (indirect) returns M[M[k]], using exactly two memory reads, the first of which fetches the pointer.
- R4: Mode code 3 (indirect, index added afterwards) returns M[(M[k] + X) mod 2^W], using two memory reads.
- R5: Mode code 4 (index added first, then indirect) returns M[M[(k + X) mod 2^W]], using two memory reads.
- R6: Mode code 5 (register-indirect) returns M[B], where B is the register chosen by `base_sel`, using one memory read.
- R7: Mode code 6 (base plus index) returns M[(B + X) mod 2^W], with B from `base_sel` and X from `idx_sel`, using one memory read.
- R8: Mode code 7 is illegal. It produces `done` with `err` high and `operand` zero one cycle after acceptance, and raises no memory request. `err` is low for every other mode.
- R9: While `mem_req` is high and `mem_valid` is low, `mem_req` stays high and `mem_addr` stays unchanged. Any number of wait cycles is tolerated.
- R10: A `start` that arrives while `busy` is high has no effect. Each accepted start yields exactly one `done`.
- R11: `done` is high for exactly one cycle, with `operand` valid in that cycle and `mem_req` low. Under reset `busy`, `done`, `err` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a resolution; sampled only while idle |
| mode | input | 3 | Addressing mode code (0..6 legal, 7 illegal) |
| addr_const | input | WORD_W | Address constant from the instruction |
| idx_sel | input | RSW | Register number supplying the index |
| base_sel | input | RSW | Register number supplying the base or the register pointer |
| rf_addr | output | RSW | Register-file read address |
| rf_data | input | WORD_W | Register-file read data, same cycle as `rf_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | WORD_W | Memory read address |
| mem_valid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | WORD_W | Memory read data |
| busy | output | 1 | Unit is resolving an operand |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal mode, valid with `done` |
| operand | output | WORD_W | Final operand, valid with `done` |

## Verification
Two events can fall in the same cycle: a fresh `start` and the completion of the previous operation. In the `done` cycle the unit still reports busy, so a start there must be dropped. The bench provokes this by holding `start` high with junk fields, illegal mode codes among them, from acceptance through the `done` cycle. The scoreboard then checks that every `done` matches a queued expectation with the right operand and read count, and that no unmatched `done` appears. Random memory wait states also make a pointer read's completion land right next to the request of the second read.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RIX,
    ST_RBASE,
    ST_PTR,
    ST_OPND,
    ST_FIN
  } ea_state_e;

  localparam logic [2:0] MD_ABS  = 3'd0;
  localparam logic [2:0] MD_IDX  = 3'd1;
  localparam logic [2:0] MD_IND  = 3'd2;
  localparam logic [2:0] MD_POST = 3'd3;
  localparam logic [2:0] MD_PRE  = 3'd4;
  localparam logic [2:0] MD_RIND = 3'd5;
  localparam logic [2:0] MD_BIDX = 3'd6;
  localparam logic [2:0] MD_BAD  = 3'd7;

  function automatic logic md_needs_ix(input logic [2:0] m);
    return (m == MD_IDX) || (m == MD_POST) || (m == MD_PRE) || (m == MD_BIDX);
  endfunction

  function automatic logic md_needs_base(input logic [2:0] m);
    return (m == MD_RIND) || (m == MD_BIDX);
  endfunction

  function automatic logic md_is_indirect(input logic [2:0] m);
    return (m == MD_IND) || (m == MD_POST) || (m == MD_PRE);
  endfunction

endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  ea_state_e  state_q,
  input  logic       start,
  input  logic [2:0] mode_in,
  input  logic [2:0] mode_q,
  input  logic       mem_valid,
  output ea_state_e  state_d,
  output logic       accept
);
  assign accept = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (mode_in == MD_BAD)            state_d = ST_FIN;
          else if (md_needs_ix(mode_in))    state_d = ST_RIX;
          else if (md_needs_base(mode_in))  state_d = ST_RBASE;
          else if (md_is_indirect(mode_in)) state_d = ST_PTR;
          else                              state_d = ST_OPND;
        end
      end
      ST_RIX: begin
        if (md_needs_base(mode_q))       state_d = ST_RBASE;
        else if (md_is_indirect(mode_q)) state_d = ST_PTR;
        else                             state_d = ST_OPND;
      end
      ST_RBASE: state_d = ST_OPND;
      ST_PTR:   if (mem_valid) state_d = ST_OPND;
      ST_OPND:  if (mem_valid) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              ptr_phase,
  input  logic [2:0]        mode,
  input  logic [WORD_W-1:0] konst,
  input  logic [WORD_W-1:0] ix,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] ptr,
  output logic [WORD_W-1:0] addr
);
  always_comb begin
    if (ptr_phase) begin
      addr = (mode == MD_PRE) ? konst + ix : konst;
    end else begin
      case (mode)
        MD_ABS:  addr = konst;
        MD_IDX:  addr = konst + ix;
        MD_IND:  addr = ptr;
        MD_POST: addr = ptr + ix;
        MD_PRE:  addr = ptr;
        MD_RIND: addr = base;
        MD_BIDX: addr = base + ix;
        default: addr = konst;
      endcase
    end
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int WORD_W      = 10,
  parameter int RSW         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [WORD_W-1:0] addr_const,
  input  logic [RSW-1:0]    idx_sel,
  input  logic [RSW-1:0]    base_sel,
  output logic [RSW-1:0]    rf_addr,
  input  logic [WORD_W-1:0] rf_data,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] operand
);
  logic rst_sync_n;

  ea_rst_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ea_state_e         state_q, state_d;
  logic              accept;
  logic [2:0]        mode_q;
  logic [WORD_W-1:0] konst_q, ix_q, base_q, ptr_q, opnd_q, opnd_d;
  logic [RSW-1:0]    isel_q, bsel_q;
  logic              err_q;
  logic              ix_en, base_en, ptr_en, opnd_en;

  ea_ctrl ctrl_i (
    .state_q   (state_q),
    .start     (start),
    .mode_in   (mode),
    .mode_q    (mode_q),
    .mem_valid (mem_valid),
    .state_d   (state_d),
    .accept    (accept)
  );

  ea_addr_gen #(.WORD_W(WORD_W)) agen_i (
    .ptr_phase (state_q == ST_PTR),
    .mode      (mode_q),
    .konst     (konst_q),
    .ix        (ix_q),
    .base      (base_q),
    .ptr       (ptr_q),
    .addr      (mem_addr)
  );

  // enables for the datapath registers
  always_comb begin
    ix_en   = (state_q == ST_RIX);
    base_en = (state_q == ST_RBASE);
    ptr_en  = (state_q == ST_PTR) && mem_valid;
    opnd_en = accept || ((state_q == ST_OPND) && mem_valid);
    opnd_d  = accept ? '0 : mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q  <= MD_ABS;
      konst_q <= '0;
      isel_q  <= '0;
      bsel_q  <= '0;
      err_q   <= 1'b0;
    end else if (accept) begin
      mode_q  <= mode;
      konst_q <= addr_const;
      isel_q  <= idx_sel;
      bsel_q  <= base_sel;
      err_q   <= (mode == MD_BAD);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ix_q <= '0;
    else if (ix_en)   ix_q <= rf_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  base_q <= '0;
    else if (base_en) base_q <= rf_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ptr_q <= '0;
    else if (ptr_en)  ptr_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  opnd_q <= '0;
    else if (opnd_en) opnd_q <= opnd_d;
  end

  assign rf_addr = (state_q == ST_RIX) ? isel_q : bsel_q;
  assign mem_req = (state_q == ST_PTR) || (state_q == ST_OPND);
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_FIN);
  assign err     = done && err_q;
  assign operand = opnd_q;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        mode,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_req,
  input logic              mem_valid,
  input logic [WORD_W-1:0] mem_addr
);
  // R9
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  // R8
  illegal_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode == 3'd7 |=> done && err && !mem_req);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode != 3'd7 |=> busy && !done);
endmodule

bind ea_unit ea_unit_chk #(.WORD_W(WORD_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .mode      (mode),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .mem_req   (mem_req),
  .mem_valid (mem_valid),
  .mem_addr  (mem_addr)
);

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
  localparam int W   = 10;
  localparam int RSW = 3;
  localparam int NW  = 1 << W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n, start, mem_req, mem_valid, busy, done, err;
  logic [2:0]     mode;
  logic [W-1:0]   addr_const, rf_data, mem_addr, mem_rdata, operand;
  logic [RSW-1:0] idx_sel, base_sel, rf_addr;

  logic [W-1:0] mem  [0:NW-1];
  logic [W-1:0] regs [0:(1<<RSW)-1];

  assign rf_data = regs[rf_addr];

  ea_unit #(.WORD_W(W), .RSW(RSW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .addr_const(addr_const), .idx_sel(idx_sel), .base_sel(base_sel),
    .rf_addr(rf_addr), .rf_data(rf_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .err(err), .operand(operand)
  );

  typedef struct {
    logic [W-1:0] opnd;
    logic         err;
    int           reads;
    int           md;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string req_of [0:7] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R8"};

  task automatic check(string req, bit ok, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] calc(int md, logic [W-1:0] k, int is, int bs,
                                        output int rd);
    logic [W-1:0] ix, b, a;
    ix = regs[is];
    b  = regs[bs];
    rd = 1;
    case (md)
      0: a = k;
      1: a = k + ix;
      2: begin a = mem[k]; rd = 2; end
      3: begin a = mem[k] + ix; rd = 2; end
      4: begin a = mem[W'(k + ix)]; rd = 2; end
      5: a = b;
      6: a = b + ix;
      default: begin rd = 0; return '0; end
    endcase
    return mem[a];
  endfunction

  task automatic launch(int md, logic [W-1:0] k, int is, int bs, bit noisy);
    exp_t e;
    int   rd;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; mode = 3'(md); addr_const = k;
    idx_sel = RSW'(is); base_sel = RSW'(bs);
    e.opnd = calc(md, k, is, bs, rd);
    e.err = (md == 7); e.reads = rd; e.md = md;
    sb_q.push_back(e);
    @(negedge clk);
    // R10: hold junk starts through the whole operation, done cycle included
    while (noisy && busy) begin
      start = 1'b1; mode = 3'd7 - mode; addr_const = ~addr_const;
      idx_sel = idx_sel + 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  // monitor and memory responder, both away from the rising edge
  int           rd_count = 0;
  int           wcnt = 0;
  int           wseed = 7;
  bit           waiting = 0;
  logic [W-1:0] hold_addr;

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check("R10", 1'b0, 1, 0, "done without an accepted start");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(req_of[e.md], operand == e.opnd, int'(operand), int'(e.opnd), "operand");
        check("R8", err == e.err, int'(err), int'(e.err), "err flag");
        check(req_of[e.md], rd_count == e.reads, rd_count, e.reads, "memory reads");
      end
      rd_count = 0;
    end
    if (mem_req && !mem_valid) begin
      if (!waiting) begin
        waiting = 1;
        hold_addr = mem_addr;
        wcnt = wseed % 4;
        wseed = (wseed * 5 + 3) % 97;
      end
      if (wcnt == 0) begin
        check("R9", mem_addr == hold_addr, int'(mem_addr), int'(hold_addr), "address held");
        mem_valid = 1'b1;
        mem_rdata = mem[mem_addr];
        rd_count++;
        waiting = 0;
      end else begin
        wcnt--;
      end
    end else begin
      mem_valid = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NW; a++) mem[a] = W'((a * 317 + 91) % NW);
    for (int i = 0; i < (1 << RSW); i++) regs[i] = W'(i * 45 + 3);
    regs[7] = W'(NW - 1);
    regs[6] = W'(NW - 16);
    rst_n = 1'b0; start = 1'b0; mode = '0; addr_const = '0;
    idx_sel = '0; base_sel = '0; mem_valid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", busy == 1'b0, int'(busy), 0, "busy in reset");
    check("R11", done == 1'b0, int'(done), 0, "done in reset");
    check("R11", mem_req == 1'b0, int'(mem_req), 0, "mem_req in reset");
    check("R11", err == 1'b0, int'(err), 0, "err in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // every mode with several patterns; odd passes also spray starts while busy
    for (int m = 0; m < 8; m++) begin
      for (int j = 0; j < 4; j++) begin
        launch(m, W'((j * 97 + m * 13 + 1) % NW), (j + m) % 8, (j * 3 + m + 1) % 8, j[0]);
      end
    end
    // R2: index wraps around the address space
    launch(1, W'(5), 7, 0, 0);
    // R7: base plus index wraps
    launch(6, W'(0), 7, 6, 1);
    // R5: pre-indexed pointer address wraps
    launch(4, W'(NW - 1), 1, 0, 0);
    // R4: post-indexed with wrapping index
    launch(3, W'(NW - 2), 7, 3, 1);
    // R3 and R6 back to back
    launch(2, W'(0), 0, 0, 0);
    launch(5, W'(0), 0, 7, 0);
    // R8 illegal mode twice in a row
    launch(7, W'(123), 2, 3, 0);
    launch(7, W'(321), 4, 5, 1);

    repeat (20) @(negedge clk);
    check("R10", sb_q.size() == 0, sb_q.size(), 0, "outstanding expectations");
    check("R11", busy == 1'b0, int'(busy), 0, "idle at end");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule